// File: doc/BRIEF.md
# Serial I/Q Output Slot Generator

This block sits at the end of a decimating receive chain and turns each complex sample into a serial bit stream. It runs on the sample clock. It opens one output slot every 4R sample clocks, where R is the programmable decimation factor of the first filter stage. A further fixed divide by four accounts for the complex-output filter stage. A programmable divider derives the serial bit clock, `serClk`, whose period is `rateField + 1` sample clocks.

Each slot carries either the I word only or the I word followed by the Q word. Every word is framed by a one-bit sync marker before it and one guard bit after it. The slot closes with one idle bit. Word length is programmable from 4 to 32 bits. The block compares the slot length in sample clocks with the 4R-clock slot period and raises an error flag when the slot cannot fit. An overlong slot is cut short by the next slot opening.

Samples arrive on a parallel port with a valid strobe. The slot sends the sample most recently captured before it opens. All configuration inputs are expected to change only while reset is held.

Top module: `iq_slot_serializer`

## Requirements
- R1: During a slot, `serClk` has a period of `rateField + 1` sample clocks. It is high for the first ceil((rateField+1)/2) of them and low for the rest. With `rateField` = 0 it stays high for the whole slot. Between slots it is low.
- R2: Slots open every 4R sample clocks. The first slot opens on rising edge number 4R-1 after reset release, counting the first edge with `rstN` high as edge 0. A `decimFactor` of 0 is treated as 1.
- R3: Each word frame has three parts. The sync bit shows `serSync`=1 and `serData`=0. Then come the L data bits, MSB first, with `serSync`=0. Then one guard bit shows both outputs at 0. With `iqMode`=1 the slot sends the I frame and then the Q frame. With `iqMode`=0 it sends the I frame only, and `sampleQ` has no effect.
- R4: After the last frame, one idle bit (both outputs 0) closes the slot. A slot therefore lasts (L+2)*M+1 serial clocks, where M is 2 when `iqMode`=1 and 1 otherwise. After that, `serClk` is low until the next slot opens.
- R5: The words sent in a slot are the low L bits of the `sampleI`/`sampleQ` values that were captured with `sampleValid` at the last rising edge before the slot-opening edge.
- R6: The effective word length L is `wordLen` clamped into the range 4 to 32. For example, a `wordLen` of 2 sends 4-bit words.
- R7: `slotErr` is 1 exactly when (`rateField`+1) * ((L+2)*M+1) > 4R. It is registered, so it is valid from the first edge after reset release, and it is 0 in reset.
- R8: When a slot overruns, the next slot opening aborts it. The new slot's sync bit appears on the opening edge.
- R9: `serData` and `serSync` change only on the edges where `serClk` rises. The exceptions are `rateField` = 0 and a slot opening.
- R10: While `rstN` is low, `serClk`, `serData`, `serSync` and `slotErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Synchronous reset, active low |
| decimFactor | input | 12 | First-stage decimation factor R |
| rateField | input | 8 | Serial clock divider; period is rateField+1 clocks |
| wordLen | input | 6 | Requested output word length in bits |
| iqMode | input | 1 | 1: I then Q per slot; 0: I only |
| sampleValid | input | 1 | Capture strobe for sampleI/sampleQ |
| sampleI | input | 32 | In-phase sample word |
| sampleQ | input | 32 | Quadrature sample word |
| serClk | output | 1 | Serial bit clock |
| serData | output | 1 | Serial data, MSB first |
| serSync | output | 1 | High during each word's sync bit |
| slotErr | output | 1 | Slot does not fit the 4R-clock period |

## Verification
The bench targets the exact-fit configuration, where the closing idle bit ends on the clock before the next slot opens. A design whose fit test used the wrong inequality would flag this case as an error, and one that mis-sized the idle bit would overlap the next sync. It drives a rate one step too large for a 32-bit I-then-Q slot and expects the opening sync on edge 8R-1. A design that let an overrunning slot finish would show data there instead of sync. Word-length clamping, a decimation factor of 0 and a divider of 0 are each run. A design that missed one of them would send words of the wrong width, open slots at the wrong spacing, or toggle the serial clock when it should stay high. Finally, the Q input is randomised in single-word mode, so a design that leaked Q into the stream would send an extra frame.

// File: rtl/iqs_pkg.sv
package iqs_pkg;

  // What the serial outputs show during the current bit period.
  typedef enum logic [2:0] {
    BK_IDLE  = 3'd0,
    BK_SYNC  = 3'd1,
    BK_DATA  = 3'd2,
    BK_GUARD = 3'd3,
    BK_TAIL  = 3'd4
  } bitKind_e;

  // Strobes from the slot control to the shift datapath.
  typedef struct packed {
    logic     slotLoad;  // slot opens: capture words, load I
    logic     advance;   // bit boundary: update output enables
    logic     loadQ;     // Q frame starts: reload shifter
    logic     shift;     // next data bit
    bitKind_e nextKind;  // kind of the bit about to be shown
  } pathCtl_t;

endpackage

// File: rtl/iqs_slot_timer.sv
module iqs_slot_timer #(
  parameter int WORD_W  = 32,
  parameter int DECIM_W = 12,
  parameter int RATE_W  = 8,
  parameter int LEN_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DECIM_W-1:0] decimFactor,
  input  logic [RATE_W-1:0]  rateField,
  input  logic [LEN_W-1:0]   wordLen,
  input  logic               iqMode,
  output logic [LEN_W-1:0]   effLen,
  output logic               slotStart,
  output logic               slotErr
);

  localparam int MIN_LEN = 4;
  localparam int SLOT_W  = LEN_W + 2;
  localparam int NEED_W  = RATE_W + 1 + SLOT_W;
  localparam int AVAIL_W = DECIM_W + 2;
  localparam int CMP_W   = (NEED_W > AVAIL_W) ? NEED_W : AVAIL_W;

  logic [DECIM_W-1:0] effR;
  logic [DECIM_W-1:0] decimCnt;
  logic               decimStrobe;
  logic [1:0]         firPhase;
  logic [SLOT_W-1:0]  slotLen;
  logic [RATE_W:0]    rateP1;
  logic [CMP_W-1:0]   needClks;
  logic [CMP_W-1:0]   availClks;

  assign effR = (decimFactor == '0) ? DECIM_W'(1) : decimFactor;

  always_comb begin
    if (wordLen < LEN_W'(MIN_LEN))      effLen = LEN_W'(MIN_LEN);
    else if (wordLen > LEN_W'(WORD_W))  effLen = LEN_W'(WORD_W);
    else                                effLen = wordLen;
  end

  // First-stage decimation counter: preload R-1, strobe at zero.
  assign decimStrobe = (decimCnt == '0);
  // Fourth strobe of each group opens a slot (complex FIR decimates by 4).
  assign slotStart   = decimStrobe && (firPhase == 2'd3);

  // Fit check: (rate+1) * slot length against 4R sample clocks.
  assign slotLen   = (SLOT_W'(effLen) + SLOT_W'(2)) * (iqMode ? SLOT_W'(2) : SLOT_W'(1))
                     + SLOT_W'(1);
  assign rateP1    = {1'b0, rateField} + 1'b1;
  assign needClks  = CMP_W'(rateP1) * CMP_W'(slotLen);
  assign availClks = CMP_W'({effR, 2'b00});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decimCnt <= effR - 1'b1;
      firPhase <= 2'd0;
      slotErr  <= 1'b0;
    end else begin
      decimCnt <= decimStrobe ? (effR - 1'b1) : (decimCnt - 1'b1);
      if (decimStrobe) firPhase <= firPhase + 2'd1;
      slotErr <= (needClks > availClks);
    end
  end

  // Independent spacing counter for the slot-period check.
  logic [AVAIL_W-1:0] sinceSlot;
  logic [AVAIL_W-1:0] periodM1;
  assign periodM1 = {effR, 2'b00} - AVAIL_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)          sinceSlot <= '0;
    else if (slotStart) sinceSlot <= '0;
    else                sinceSlot <= sinceSlot + 1'b1;
  end

  assert_slot_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |-> (sinceSlot == periodM1));

  assert_err_zero_rate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rateField == '0 && availClks >= CMP_W'(slotLen)) |=> !slotErr);

endmodule

// File: rtl/iqs_slot_ctrl.sv
module iqs_slot_ctrl
  import iqs_pkg::*;
#(
  parameter int RATE_W = 8,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotStart,
  input  logic [RATE_W-1:0] rateField,
  input  logic [LEN_W-1:0]  effLen,
  input  logic              iqMode,
  output logic              serClk,
  output pathCtl_t          ctl
);

  bitKind_e          kind, nKind;
  logic [RATE_W-1:0] divCnt, nDiv;
  logic [LEN_W-1:0]  pos, nPos;
  logic              wordSel, nWordSel;
  logic              bitEnd;
  logic              adv, loadQ, doShift;
  logic [RATE_W+1:0] halfHi;
  logic              nSerClk;

  assign bitEnd = (kind != BK_IDLE) && (divCnt == rateField);
  assign halfHi = ({2'b00, rateField} + (RATE_W+2)'(2)) >> 1;

  always_comb begin
    nKind    = kind;
    nPos     = pos;
    nWordSel = wordSel;
    adv      = 1'b0;
    loadQ    = 1'b0;
    doShift  = 1'b0;
    if (slotStart) begin
      adv      = 1'b1;
      nKind    = BK_SYNC;
      nWordSel = 1'b0;
      nPos     = '0;
    end else if (bitEnd) begin
      adv = 1'b1;
      case (kind)
        BK_SYNC: begin
          nKind = BK_DATA;
          nPos  = '0;
        end
        BK_DATA: begin
          if (pos == effLen - 1'b1) begin
            nKind = BK_GUARD;
          end else begin
            nPos    = pos + 1'b1;
            doShift = 1'b1;
          end
        end
        BK_GUARD: begin
          if (iqMode && !wordSel) begin
            nKind    = BK_SYNC;
            nWordSel = 1'b1;
            loadQ    = 1'b1;
          end else begin
            nKind = BK_TAIL;
          end
        end
        default: nKind = BK_IDLE;
      endcase
    end

    if (slotStart || kind == BK_IDLE || bitEnd) nDiv = '0;
    else                                        nDiv = divCnt + 1'b1;

    nSerClk = (nKind != BK_IDLE) && ({2'b00, nDiv} < halfHi);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kind    <= BK_IDLE;
      divCnt  <= '0;
      pos     <= '0;
      wordSel <= 1'b0;
      serClk  <= 1'b0;
    end else begin
      kind    <= nKind;
      divCnt  <= nDiv;
      pos     <= nPos;
      wordSel <= nWordSel;
      serClk  <= nSerClk;
    end
  end

  assign ctl = '{slotLoad: slotStart, advance: adv, loadQ: loadQ,
                 shift: doShift, nextKind: nKind};

  assert_tail_closes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (kind == BK_TAIL && bitEnd && !slotStart) |=> (kind == BK_IDLE && !serClk));

  assert_clk_low_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (kind == BK_IDLE) |-> !serClk);

  assert_pos_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (kind == BK_DATA) |-> (pos < effLen));

endmodule

// File: rtl/iqs_shift_path.sv
module iqs_shift_path
  import iqs_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [LEN_W-1:0]  effLen,
  input  logic              sampleValid,
  input  logic [WORD_W-1:0] sampleI,
  input  logic [WORD_W-1:0] sampleQ,
  output logic              serData,
  output logic              serSync
);

  logic [WORD_W-1:0] pendI, pendQ, holdQ, shReg;
  logic [LEN_W-1:0]  shAmt;
  logic              syncEn, dataEn;

  // Left-align the low effLen bits so the word MSB sits at the top.
  assign shAmt = LEN_W'(WORD_W) - effLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendI  <= '0;
      pendQ  <= '0;
      holdQ  <= '0;
      shReg  <= '0;
      syncEn <= 1'b0;
      dataEn <= 1'b0;
    end else begin
      if (sampleValid) begin
        pendI <= sampleI;
        pendQ <= sampleQ;
      end
      if (ctl.slotLoad) begin
        shReg <= pendI << shAmt;
        holdQ <= pendQ;
      end else if (ctl.loadQ) begin
        shReg <= holdQ << shAmt;
      end else if (ctl.shift) begin
        shReg <= shReg << 1;
      end
      if (ctl.advance) begin
        syncEn <= (ctl.nextKind == BK_SYNC);
        dataEn <= (ctl.nextKind == BK_DATA);
      end
    end
  end

  assign serData = dataEn & shReg[WORD_W-1];
  assign serSync = syncEn;

  assert_frame_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({syncEn, dataEn}));

  assert_q_sync_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadQ |=> (syncEn && !serData));

endmodule

// File: rtl/iq_slot_serializer.sv
module iq_slot_serializer
  import iqs_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int DECIM_W = 12,
  parameter int RATE_W  = 8,
  parameter int LEN_W   = $clog2(WORD_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DECIM_W-1:0] decimFactor,
  input  logic [RATE_W-1:0]  rateField,
  input  logic [LEN_W-1:0]   wordLen,
  input  logic               iqMode,
  input  logic               sampleValid,
  input  logic [WORD_W-1:0]  sampleI,
  input  logic [WORD_W-1:0]  sampleQ,
  output logic               serClk,
  output logic               serData,
  output logic               serSync,
  output logic               slotErr
);

  logic [LEN_W-1:0] effLen;
  logic             slotStart;
  pathCtl_t         ctl;

  iqs_slot_timer #(
    .WORD_W(WORD_W), .DECIM_W(DECIM_W), .RATE_W(RATE_W), .LEN_W(LEN_W)
  ) u_timer (
    .clk(clk), .rstN(rstN), .decimFactor(decimFactor), .rateField(rateField),
    .wordLen(wordLen), .iqMode(iqMode), .effLen(effLen),
    .slotStart(slotStart), .slotErr(slotErr)
  );

  iqs_slot_ctrl #(
    .RATE_W(RATE_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .slotStart(slotStart), .rateField(rateField),
    .effLen(effLen), .iqMode(iqMode), .serClk(serClk), .ctl(ctl)
  );

  iqs_shift_path #(
    .WORD_W(WORD_W), .LEN_W(LEN_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .effLen(effLen),
    .sampleValid(sampleValid), .sampleI(sampleI), .sampleQ(sampleQ),
    .serData(serData), .serSync(serSync)
  );

  assert_data_on_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({serData, serSync}) |-> ($rose(serClk) || rateField == '0 || $past(slotStart)));

endmodule

// File: tb/iq_slot_serializer_bench.sv
module iq_slot_serializer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] decimFactor = '0;
  logic [7:0]  rateField = '0;
  logic [5:0]  wordLen = 6'd8;
  logic        iqMode = 1'b0;
  logic        sampleValid = 1'b0;
  logic [31:0] sampleI = '0;
  logic [31:0] sampleQ = '0;
  logic        serClk, serData, serSync, slotErr;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expQ[$];

  always #5 clk = ~clk;

  iq_slot_serializer u_iq_slot_serializer (
    .clk(clk), .rstN(rstN), .decimFactor(decimFactor), .rateField(rateField),
    .wordLen(wordLen), .iqMode(iqMode), .sampleValid(sampleValid),
    .sampleI(sampleI), .sampleQ(sampleQ), .serClk(serClk), .serData(serData),
    .serSync(serSync), .slotErr(slotErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int effLenOf(input int w);
    if (w < 4) return 4;
    if (w > 32) return 32;
    return w;
  endfunction

  function automatic int slotLenOf(input int len, input bit iq);
    return (len + 2) * (iq ? 2 : 1) + 1;
  endfunction

  function automatic logic [31:0] lowBits(input logic [31:0] w, input int len);
    if (len >= 32) return w;
    return w & ((32'd1 << len) - 32'd1);
  endfunction

  task automatic applyReset(input bit checkIdle);
    rstN = 1'b0;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    if (checkIdle) begin
      check(serClk == 1'b0, "R10", "serClk in reset", 32'(serClk), 0);
      check(serData == 1'b0, "R10", "serData in reset", 32'(serData), 0);
      check(serSync == 1'b0, "R10", "serSync in reset", 32'(serSync), 0);
      check(slotErr == 1'b0, "R10", "slotErr in reset", 32'(slotErr), 0);
    end
    rstN = 1'b1;
  endtask

  // Driver: one fresh sample per slot, captured at edge 4Rn+1.
  task automatic driveSamples(input int r, input int len, input bit iq, input int nSlots);
    int cur = -1;
    for (int n = 0; n < nSlots; n++) begin
      int target = 4 * r * n;
      repeat (target - cur) @(negedge clk);
      cur = target;
      sampleI = $urandom;
      sampleQ = $urandom;
      sampleValid = 1'b1;
      expQ.push_back(lowBits(sampleI, len));
      if (iq) expQ.push_back(lowBits(sampleQ, len));
      @(negedge clk);
      cur++;
      sampleValid = 1'b0;
    end
  endtask

  // Monitor: decode the stream on serClk rises and compare with the queue.
  task automatic monitorSlots(input int r, input int rate, input int len, input bit iq,
                              input int nSlots, input string wordTag);
    int cyc = -1, slot = 0, wIdx = 0, st = 0, cnt = 0, riseCnt = 0;
    int lastRise = -1000, tailCyc = -1;
    int mode = iq ? 2 : 1;
    int sl = slotLenOf(len, iq);
    bit expErr = ((rate + 1) * sl) > (4 * r);
    logic [31:0] acc = '0;
    logic [31:0] expW;
    logic prevClk = 1'b0, prevData = 1'b0, prevSync = 1'b0;
    while (slot < nSlots) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) check(slotErr == expErr, "R7", "slotErr", 32'(slotErr), 32'(expErr));
      if (tailCyc >= 0 && cyc == tailCyc + rate + 1) begin
        check(serClk == (cyc == 4 * r - 1 + slot * 4 * r), "R4", "serClk after slot",
              32'(serClk), 32'(cyc == 4 * r - 1 + slot * 4 * r));
        tailCyc = -1;
      end
      if (serClk && !prevClk) begin
        riseCnt++;
        if (st != 0 || wIdx != 0)
          check(cyc - lastRise == rate + 1, "R1", "serClk period", 32'(cyc - lastRise),
                32'(rate + 1));
        lastRise = cyc;
        case (st)
          0: begin
            check(serSync && !serData, "R3", "sync bit", {30'd0, serSync, serData}, 32'h2);
            if (wIdx == 0) begin
              check(cyc == 4 * r - 1 + slot * 4 * r, "R2", "slot open edge", 32'(cyc),
                    32'(4 * r - 1 + slot * 4 * r));
              riseCnt = 1;
            end
            acc = '0;
            cnt = 0;
            st = 1;
          end
          1: begin
            check(!serSync, "R3", "sync during data", 32'(serSync), 0);
            acc = {acc[30:0], serData};
            cnt++;
            if (cnt == len) st = 2;
          end
          2: begin
            check(!serSync && !serData, "R3", "guard bit", {30'd0, serSync, serData}, 0);
            expW = (expQ.size() > 0) ? expQ.pop_front() : 32'hdeadbeef;
            check(acc == expW, wordTag, "serial word", acc, expW);
            wIdx++;
            st = (wIdx == mode) ? 3 : 0;
          end
          default: begin
            check(!serSync && !serData, "R4", "closing idle bit", {30'd0, serSync, serData}, 0);
            check(riseCnt == sl, "R4", "slot length", 32'(riseCnt), 32'(sl));
            slot++;
            wIdx = 0;
            st = 0;
            tailCyc = cyc;
          end
        endcase
      end else if (cyc > 0) begin
        check(serData == prevData && serSync == prevSync, "R9", "change without serClk rise",
              {30'd0, serSync, serData}, {30'd0, prevSync, prevData});
      end
      prevClk = serClk;
      prevData = serData;
      prevSync = serSync;
    end
  endtask

  task automatic runStream(input int r, input int rate, input int wl, input bit iq,
                           input int nSlots, input string wordTag);
    int len = effLenOf(wl);
    decimFactor = 12'(r);
    rateField = 8'(rate);
    wordLen = 6'(wl);
    iqMode = iq;
    expQ.delete();
    applyReset(1'b0);
    fork
      driveSamples(r, len, iq, nSlots);
      monitorSlots(r, rate, len, iq, nSlots, wordTag);
    join
    check(expQ.size() == 0, "R5", "words left unsent", 32'(expQ.size()), 0);
  endtask

  task automatic waitNeg(inout int cyc, input int target);
    repeat (target - cyc) @(negedge clk);
    cyc = target;
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int cyc;
    // Reset state, R10
    decimFactor = 12'd20; rateField = 8'd1; wordLen = 6'd8; iqMode = 1'b1;
    applyReset(1'b1);

    // I then Q, small configuration
    runStream(20, 1, 8, 1'b1, 3, "R5");
    // 32-bit I then Q at the largest rate that fits
    runStream(100, 4, 32, 1'b1, 3, "R5");
    // Single word: Q randomised but ignored (R3)
    runStream(5, 1, 4, 1'b0, 4, "R3");
    // wordLen 2 clamps to 4 bits (R6)
    runStream(8, 2, 2, 1'b0, 3, "R6");
    // Exact fit: slot fills the whole 4R period, slotErr stays 0 (R7)
    runStream(21, 3, 8, 1'b1, 3, "R5");

    // Overrun: rate one step too large, slot truncated (R7, R8)
    decimFactor = 12'd100; rateField = 8'd5; wordLen = 6'd32; iqMode = 1'b1;
    applyReset(1'b0);
    cyc = -1;
    waitNeg(cyc, 1);
    check(slotErr == 1'b1, "R7", "slotErr on overrun", 32'(slotErr), 1);
    waitNeg(cyc, 798);
    check(serSync == 1'b0, "R8", "data bit before restart", 32'(serSync), 0);
    waitNeg(cyc, 799);
    check(serSync && serClk, "R8", "sync on restart edge", {30'd0, serSync, serClk}, 32'h3);

    // rateField 0: serClk held high through the slot (R1)
    decimFactor = 12'd10; rateField = 8'd0; wordLen = 6'd4; iqMode = 1'b0;
    applyReset(1'b0);
    cyc = -1;
    waitNeg(cyc, 38);
    check(serClk == 1'b0, "R1", "serClk before slot", 32'(serClk), 0);
    waitNeg(cyc, 39);
    check(serClk && serSync, "R1", "slot open, rate 0", {30'd0, serClk, serSync}, 32'h3);
    waitNeg(cyc, 40);
    check(serClk && !serSync, "R1", "data bit, rate 0", {30'd0, serClk, serSync}, 32'h2);
    waitNeg(cyc, 45);
    check(serClk == 1'b1, "R1", "idle bit, rate 0", 32'(serClk), 1);
    waitNeg(cyc, 46);
    check(serClk == 1'b0, "R1", "serClk after slot, rate 0", 32'(serClk), 0);

    // decimFactor 0 behaves as 1: slots every 4 clocks, overrun restarts (R2)
    decimFactor = 12'd0; rateField = 8'd0; wordLen = 6'd4; iqMode = 1'b0;
    applyReset(1'b0);
    cyc = -1;
    waitNeg(cyc, 1);
    check(slotErr == 1'b1, "R7", "slotErr with R treated as 1", 32'(slotErr), 1);
    waitNeg(cyc, 3);
    check(serSync == 1'b1, "R2", "first slot with R=0", 32'(serSync), 1);
    waitNeg(cyc, 6);
    check(serSync == 1'b0, "R2", "data bit with R=0", 32'(serSync), 0);
    waitNeg(cyc, 7);
    check(serSync == 1'b1, "R8", "second slot with R=0", 32'(serSync), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule